// File: doc/BRIEF.md
# Single-Cycle MIPS-Subset Processor Core

This core executes a fixed subset of 32-bit MIPS integer instructions and finishes each one in a single clock cycle. It holds its own instruction store of 32 words and data store of 16 words, a 32-entry register file with two read ports and one write port, a program counter, next-address logic, an immediate extender, a 32-bit ALU, and a multiply/divide unit that writes a HI/LO register pair. The current instruction is the combinational read of the instruction store at the program counter.

A two-state controller governs the core. `ST_IDLE` is entered on reset. In that state the memories accept preload writes and the program counter holds its value. The transition `IDLE->RUN` happens when `start` is seen; it loads `start_addr` (with the low two bits cleared) into the PC. In `ST_RUN` one instruction retires on every rising edge. The `RUN->RUN` transition is the only one available from there, and the core leaves `ST_RUN` only through reset. A program normally ends in a jump or branch to itself. The surrounding logic then reads results from the data store through a combinational peek port.

Field layout: op[31:26], rs[25:21], rt[20:16], rd[15:11], shamt[10:6], funct[5:0], imm[15:0], index[25:0]. Byte addresses select words by bits [n+1:2], and addresses beyond each store wrap around inside it.

Top module: `sc_core`

## Requirements
- R1: While reset (`rst_n` low, asynchronous) is asserted, the core enters `ST_IDLE` with `pc_q`=0 and `busy`=0, and all registers plus HI and LO are cleared. The memories are not cleared.
- R2: In `ST_IDLE`, `start`=1 at a rising edge moves the core to `ST_RUN` and loads `start_addr & ~3` into `pc_q`. Without `start`, the PC holds. `start` has no effect in `ST_RUN`.
- R3: In `ST_RUN` one instruction retires per cycle and the PC advances by 4 unless control is redirected. Any encoding not listed below acts as a no-op.
- R4: For R-type instructions (op 0x00) the result goes to rd. The functs are add 0x20, addu 0x21, sub 0x22, subu 0x23, and 0x24 and nor 0x27. Arithmetic wraps with no overflow trap.
- R5: addi (op 0x08) and addiu (0x09) sign-extend imm and add it to rs. andi (0x0C) and ori (0x0D) zero-extend imm. In all four the result goes to rt.
- R6: sll (funct 0x00), srl (0x02) and sra (0x03) shift rt by shamt and write rd. srl fills with zeros and sra fills with the sign bit.
- R7: lw (op 0x23) loads rt and sw (op 0x2B) stores rt, both at the address rs + sign-extended imm. The data word index is address bits [5:2].
- R8: beq (op 0x04) and bne (op 0x05) compare rs with rt. When the branch is taken, the next PC is PC+4 + (sign-extended imm << 2). Otherwise it is PC+4. There is no delay slot.
- R9: j (op 0x02) sets the PC to {(PC+4)[31:28], index, 2'b00}.
- R10: mult (funct 0x18) places the signed 64-bit product of rs and rt in HI (upper) and LO (lower). mfhi (0x10) and mflo (0x12) copy HI or LO into rd.
- R11: div (funct 0x1A) places the signed quotient (truncated toward zero) in LO and the remainder in HI. With rt = 0, HI and LO are left unchanged.
- R12: Register 0 always reads as zero, and writes to it are discarded.
- R13: Preload writes (`pre_iwe`, `pre_dwe`) take effect at a rising edge only in `ST_IDLE` and are ignored in `ST_RUN`. `peek_ddata` always shows data word `pre_daddr`.
- R14: A program that accumulates the sum of x(i)*y(i) for i = 1..5 with lw, mult, mflo, add, addi and bne stores the correct Z in data memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin execution from `start_addr` (honoured in ST_IDLE) |
| start_addr | input | 32 | Byte address of the first instruction |
| pre_iwe | input | 1 | Instruction store preload write enable |
| pre_iaddr | input | IA_W (5) | Instruction word index for preload |
| pre_idata | input | 32 | Instruction word to preload |
| pre_dwe | input | 1 | Data store preload write enable |
| pre_daddr | input | DA_W (4) | Data word index for preload and peek |
| pre_ddata | input | 32 | Data word to preload |
| peek_ddata | output | 32 | Combinational read of data word `pre_daddr` |
| pc_q | output | 32 | Current program counter |
| busy | output | 1 | High in ST_RUN |

## Verification
Some properties are checked on every cycle. These are: the PC holding in idle, sequential PC advance when no branch or jump is taken, the stored word matching the rt value after every sw, preload writes leaving data memory untouched while running, register 0 never changing, LO after every mult, and HI/LO holding across a divide by zero. Other behaviour is shown only by the bench's programs. That covers each opcode's arithmetic result, the sign- and zero-extension choices, taken and untaken branches in both directions, the jump target, HI/LO clearing on reset, and the five-element dot product.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int XLEN = 32;

    // primary opcodes
    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_J     = 6'h02;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_BNE   = 6'h05;
    localparam logic [5:0] OP_ADDI  = 6'h08;
    localparam logic [5:0] OP_ADDIU = 6'h09;
    localparam logic [5:0] OP_ANDI  = 6'h0C;
    localparam logic [5:0] OP_ORI   = 6'h0D;
    localparam logic [5:0] OP_LW    = 6'h23;
    localparam logic [5:0] OP_SW    = 6'h2B;

    // function codes of R-type
    localparam logic [5:0] FN_SLL  = 6'h00;
    localparam logic [5:0] FN_SRL  = 6'h02;
    localparam logic [5:0] FN_SRA  = 6'h03;
    localparam logic [5:0] FN_MFHI = 6'h10;
    localparam logic [5:0] FN_MFLO = 6'h12;
    localparam logic [5:0] FN_MULT = 6'h18;
    localparam logic [5:0] FN_DIV  = 6'h1A;
    localparam logic [5:0] FN_ADD  = 6'h20;
    localparam logic [5:0] FN_ADDU = 6'h21;
    localparam logic [5:0] FN_SUB  = 6'h22;
    localparam logic [5:0] FN_SUBU = 6'h23;
    localparam logic [5:0] FN_AND  = 6'h24;
    localparam logic [5:0] FN_NOR  = 6'h27;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR,
        ALU_NOR, ALU_SLL, ALU_SRL, ALU_SRA
    } alu_op_e;

    typedef enum logic [1:0] {
        WB_ALU, WB_MEM, WB_HI, WB_LO
    } wb_sel_e;

    typedef enum logic {
        ST_IDLE, ST_RUN
    } run_state_e;

    typedef struct packed {
        logic    reg_we;
        logic    dst_rd;
        logic    alu_imm;
        logic    ext_sign;
        alu_op_e alu_op;
        logic    mem_we;
        wb_sel_e wb_sel;
        logic    br_eq;
        logic    br_ne;
        logic    jump;
        logic    md_mul;
        logic    md_div;
    } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  logic [5:0] op,
    input  logic [5:0] fn,
    output ctrl_t      ctrl
);

    always_comb begin
        ctrl = '{reg_we: 1'b0, dst_rd: 1'b0, alu_imm: 1'b0, ext_sign: 1'b0,
                 alu_op: ALU_ADD, mem_we: 1'b0, wb_sel: WB_ALU,
                 br_eq: 1'b0, br_ne: 1'b0, jump: 1'b0,
                 md_mul: 1'b0, md_div: 1'b0};
        unique case (op)
            OP_RTYPE: begin
                ctrl.dst_rd = 1'b1;
                ctrl.reg_we = 1'b1;
                unique case (fn)
                    FN_ADD, FN_ADDU: ctrl.alu_op = ALU_ADD;
                    FN_SUB, FN_SUBU: ctrl.alu_op = ALU_SUB;
                    FN_AND:          ctrl.alu_op = ALU_AND;
                    FN_NOR:          ctrl.alu_op = ALU_NOR;
                    FN_SLL:          ctrl.alu_op = ALU_SLL;
                    FN_SRL:          ctrl.alu_op = ALU_SRL;
                    FN_SRA:          ctrl.alu_op = ALU_SRA;
                    FN_MFHI:         ctrl.wb_sel = WB_HI;
                    FN_MFLO:         ctrl.wb_sel = WB_LO;
                    FN_MULT: begin
                        ctrl.reg_we = 1'b0;
                        ctrl.md_mul = 1'b1;
                    end
                    FN_DIV: begin
                        ctrl.reg_we = 1'b0;
                        ctrl.md_div = 1'b1;
                    end
                    default:         ctrl.reg_we = 1'b0;
                endcase
            end
            OP_ADDI, OP_ADDIU: begin
                ctrl.reg_we   = 1'b1;
                ctrl.alu_imm  = 1'b1;
                ctrl.ext_sign = 1'b1;
            end
            OP_ANDI: begin
                ctrl.reg_we  = 1'b1;
                ctrl.alu_imm = 1'b1;
                ctrl.alu_op  = ALU_AND;
            end
            OP_ORI: begin
                ctrl.reg_we  = 1'b1;
                ctrl.alu_imm = 1'b1;
                ctrl.alu_op  = ALU_OR;
            end
            OP_LW: begin
                ctrl.reg_we   = 1'b1;
                ctrl.alu_imm  = 1'b1;
                ctrl.ext_sign = 1'b1;
                ctrl.wb_sel   = WB_MEM;
            end
            OP_SW: begin
                ctrl.mem_we   = 1'b1;
                ctrl.alu_imm  = 1'b1;
                ctrl.ext_sign = 1'b1;
            end
            OP_BEQ: begin
                ctrl.br_eq    = 1'b1;
                ctrl.ext_sign = 1'b1;
            end
            OP_BNE: begin
                ctrl.br_ne    = 1'b1;
                ctrl.ext_sign = 1'b1;
            end
            OP_J:    ctrl.jump = 1'b1;
            default: ctrl.reg_we = 1'b0;
        endcase
    end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int NREG = 32,
    parameter int W    = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);

    logic [W-1:0] regs [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
    assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];

    // R12
    zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wa == '0) |=> $stable(regs[0]) && regs[0] == '0);

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = 32,
    localparam int SW = $clog2(W)
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [SW-1:0]  shamt,
    output logic [W-1:0]   y
);

    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_NOR: y = ~(a | b);
            ALU_SLL: y = b << shamt;
            ALU_SRL: y = b >> shamt;
            ALU_SRA: y = $signed(b) >>> shamt;
        endcase
    end

endmodule

// File: rtl/sc_muldiv.sv
module sc_muldiv #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         do_mul,
    input  logic         do_div,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] hi_q,
    output logic [W-1:0] lo_q
);

    logic [2*W-1:0] prod;
    logic [W-1:0]   quo;
    logic [W-1:0]   rem;
    logic           div_ok;

    always_comb begin
        prod   = {{W{op_a[W-1]}}, op_a} * {{W{op_b[W-1]}}, op_b};
        div_ok = (op_b != '0);
        quo    = '0;
        rem    = '0;
        if (div_ok) begin
            quo = W'($signed(op_a) / $signed(op_b));
            rem = W'($signed(op_a) % $signed(op_b));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (en && do_mul) begin
            hi_q <= prod[2*W-1:W];
            lo_q <= prod[W-1:0];
        end else if (en && do_div && div_ok) begin
            hi_q <= rem;
            lo_q <= quo;
        end
    end

    // R10
    mul_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && do_mul) |=> lo_q == $past(op_a * op_b));

    // R11
    div_zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && do_div && !do_mul && op_b == '0) |=> $stable(hi_q) && $stable(lo_q));

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int IMEM_WORDS = 32,
    parameter int DMEM_WORDS = 16,
    parameter int NREG       = 32,
    localparam int IA_W = $clog2(IMEM_WORDS),
    localparam int DA_W = $clog2(DMEM_WORDS),
    localparam int RA_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [XLEN-1:0]   start_addr,
    input  logic              pre_iwe,
    input  logic [IA_W-1:0]   pre_iaddr,
    input  logic [XLEN-1:0]   pre_idata,
    input  logic              pre_dwe,
    input  logic [DA_W-1:0]   pre_daddr,
    input  logic [XLEN-1:0]   pre_ddata,
    output logic [XLEN-1:0]   peek_ddata,
    output logic [XLEN-1:0]   pc_q,
    output logic              busy
);

    run_state_e state_q, state_d;
    logic       run_en, pre_open;

    logic [XLEN-1:0] pc_d, instr, pc_plus4, br_target, jmp_target;
    logic [XLEN-1:0] imm_ext, rs_val, rt_val, alu_b, alu_res, mem_rdata, wb_data;
    logic [XLEN-1:0] hi_q, lo_q;
    ctrl_t           ctrl;
    logic            take_br;
    logic [RA_W-1:0] wa;
    logic [IA_W-1:0] i_idx;
    logic [DA_W-1:0] d_idx;

    logic [XLEN-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];

    // ---------------- run controller ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = start ? ST_RUN : ST_IDLE;
            ST_RUN:  state_d = ST_RUN;
        endcase
    end

    always_comb begin
        run_en   = 1'b0;
        pre_open = 1'b0;
        pc_d     = pc_q;
        unique case (state_q)
            ST_IDLE: begin
                pre_open = 1'b1;
                if (start) pc_d = start_addr & ~32'd3;
            end
            ST_RUN: begin
                run_en = 1'b1;
                if (ctrl.jump)   pc_d = jmp_target;
                else if (take_br) pc_d = br_target;
                else             pc_d = pc_plus4;
            end
        endcase
    end

    assign busy = (state_q == ST_RUN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    // ---------------- fetch and decode ----------------
    always_ff @(posedge clk) begin
        if (pre_open && pre_iwe) imem[pre_iaddr] <= pre_idata;
    end

    assign i_idx = pc_q[IA_W+1:2];
    assign instr = imem[i_idx];

    sc_decode u_dec (
        .op   (instr[31:26]),
        .fn   (instr[5:0]),
        .ctrl (ctrl)
    );

    assign imm_ext = ctrl.ext_sign ? {{16{instr[15]}}, instr[15:0]}
                                   : {16'd0, instr[15:0]};
    assign wa      = ctrl.dst_rd ? instr[15:11] : instr[20:16];

    // ---------------- next address ----------------
    assign pc_plus4   = pc_q + 32'd4;
    assign br_target  = pc_plus4 + {imm_ext[29:0], 2'b00};
    assign jmp_target = {pc_plus4[31:28], instr[25:0], 2'b00};
    assign take_br    = (ctrl.br_eq && (rs_val == rt_val)) ||
                        (ctrl.br_ne && (rs_val != rt_val));

    // ---------------- execute ----------------
    sc_regfile #(.NREG(NREG), .W(XLEN)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra_a  (instr[25:21]),
        .ra_b  (instr[20:16]),
        .rd_a  (rs_val),
        .rd_b  (rt_val),
        .we    (run_en && ctrl.reg_we),
        .wa    (wa),
        .wd    (wb_data)
    );

    assign alu_b = ctrl.alu_imm ? imm_ext : rt_val;

    sc_alu #(.W(XLEN)) u_alu (
        .op    (ctrl.alu_op),
        .a     (rs_val),
        .b     (alu_b),
        .shamt (instr[10:6]),
        .y     (alu_res)
    );

    sc_muldiv #(.W(XLEN)) u_md (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (run_en),
        .do_mul (ctrl.md_mul),
        .do_div (ctrl.md_div),
        .op_a   (rs_val),
        .op_b   (rt_val),
        .hi_q   (hi_q),
        .lo_q   (lo_q)
    );

    // ---------------- data memory ----------------
    assign d_idx = alu_res[DA_W+1:2];

    always_ff @(posedge clk) begin
        if (run_en && ctrl.mem_we)   dmem[d_idx]     <= rt_val;
        else if (pre_open && pre_dwe) dmem[pre_daddr] <= pre_ddata;
    end

    assign mem_rdata  = dmem[d_idx];
    assign peek_ddata = dmem[pre_daddr];

    // ---------------- write back ----------------
    always_comb begin
        unique case (ctrl.wb_sel)
            WB_ALU: wb_data = alu_res;
            WB_MEM: wb_data = mem_rdata;
            WB_HI:  wb_data = hi_q;
            WB_LO:  wb_data = lo_q;
        endcase
    end

    // ---------------- assertions ----------------
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start) |=> $stable(pc_q) && !busy);

    // R3
    seq_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ctrl.jump && !ctrl.br_eq && !ctrl.br_ne) |=> pc_q == $past(pc_q) + 32'd4);

    // R7
    store_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctrl.mem_we) |=> dmem[$past(d_idx)] == $past(rt_val));

    // R13
    preload_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && pre_dwe && !ctrl.mem_we) |=> dmem[$past(pre_daddr)] == $past(dmem[pre_daddr]));

endmodule

// File: tb/tb_sc_core.sv
`timescale 1ns/1ps
module tb_sc_core;

    localparam int IA_W = 5;
    localparam int DA_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [31:0]       start_addr = '0;
    logic              pre_iwe = 1'b0;
    logic [IA_W-1:0]   pre_iaddr = '0;
    logic [31:0]       pre_idata = '0;
    logic              pre_dwe = 1'b0;
    logic [DA_W-1:0]   pre_daddr = '0;
    logic [31:0]       pre_ddata = '0;
    logic [31:0]       peek_ddata;
    logic [31:0]       pc_q;
    logic              busy;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sc_core dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .pre_iwe(pre_iwe), .pre_iaddr(pre_iaddr), .pre_idata(pre_idata),
        .pre_dwe(pre_dwe), .pre_daddr(pre_daddr), .pre_ddata(pre_ddata),
        .peek_ddata(peek_ddata), .pc_q(pc_q), .busy(busy)
    );

    // ---------- instruction encoders ----------
    function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                          input logic [4:0] rd, input logic [4:0] sh,
                                          input logic [5:0] fn);
        return {6'h00, rs, rt, rd, sh, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] enc_j(input logic [25:0] idx);
        return {6'h02, idx};
    endfunction

    typedef struct packed {
        logic [31:0] i1;
        logic [31:0] i2;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam logic [31:0] NOP = 32'h0;

    // operand a -> r1, b -> r2, result r3 stored to word 2
    localparam vec_t VECS [NV] = '{
        '{enc_r(5'd0,5'd0,5'd3,5'd0,6'h10), NOP, 32'd1, 32'd2, 32'h0, 8'd1},          // R1 HI cleared
        '{enc_r(5'd1,5'd2,5'd3,5'd0,6'h20), NOP, 32'd5, 32'd7, 32'd12, 8'd4},         // R4 add
        '{enc_r(5'd1,5'd2,5'd3,5'd0,6'h21), NOP, 32'hFFFFFFFF, 32'd2, 32'd1, 8'd4},   // R4 addu wrap
        '{enc_r(5'd1,5'd2,5'd3,5'd0,6'h22), NOP, 32'd3, 32'd5, 32'hFFFFFFFE, 8'd4},   // R4 sub
        '{enc_r(5'd1,5'd2,5'd3,5'd0,6'h23), NOP, 32'd10, 32'd4, 32'd6, 8'd4},         // R4 subu
        '{enc_r(5'd1,5'd2,5'd3,5'd0,6'h24), NOP, 32'hF0F01234, 32'h0FF0FF00, 32'h00F01200, 8'd4}, // R4 and
        '{enc_r(5'd1,5'd2,5'd3,5'd0,6'h27), NOP, 32'hF0F0F0F0, 32'h0000000F, 32'h0F0F0F00, 8'd4}, // R4 nor
        '{enc_i(6'h08,5'd1,5'd3,16'hFFFD), NOP, 32'd10, 32'd0, 32'd7, 8'd5},          // R5 addi
        '{enc_i(6'h09,5'd1,5'd3,16'h8000), NOP, 32'd0, 32'd0, 32'hFFFF8000, 8'd5},    // R5 addiu
        '{enc_i(6'h0C,5'd1,5'd3,16'hFFFF), NOP, 32'h12345678, 32'd0, 32'h00005678, 8'd5}, // R5 andi
        '{enc_i(6'h0D,5'd1,5'd3,16'h8001), NOP, 32'h00010000, 32'd0, 32'h00018001, 8'd5}, // R5 ori
        '{enc_r(5'd0,5'd2,5'd3,5'd4,6'h00), NOP, 32'd0, 32'h0000000F, 32'h000000F0, 8'd6}, // R6 sll
        '{enc_r(5'd0,5'd2,5'd3,5'd8,6'h02), NOP, 32'd0, 32'h80000000, 32'h00800000, 8'd6}, // R6 srl
        '{enc_r(5'd0,5'd2,5'd3,5'd8,6'h03), NOP, 32'd0, 32'h80000000, 32'hFF800000, 8'd6}, // R6 sra
        '{enc_i(6'h23,5'd1,5'd3,16'h0004), NOP, 32'd0, 32'hDEADBEEF, 32'hDEADBEEF, 8'd7}, // R7 lw +4
        '{enc_i(6'h23,5'd1,5'd3,16'hFFFC), NOP, 32'd8, 32'hCAFE0001, 32'hCAFE0001, 8'd7}, // R7 lw -4
        '{enc_r(5'd1,5'd2,5'd0,5'd0,6'h18), enc_r(5'd0,5'd0,5'd3,5'd0,6'h12),
          32'hFFFFFFFD, 32'd7, 32'hFFFFFFEB, 8'd10},                                   // R10 mult lo
        '{enc_r(5'd1,5'd2,5'd0,5'd0,6'h18), enc_r(5'd0,5'd0,5'd3,5'd0,6'h10),
          32'h00010000, 32'h00010000, 32'd1, 8'd10},                                   // R10 mult hi
        '{enc_r(5'd1,5'd2,5'd0,5'd0,6'h18), enc_r(5'd0,5'd0,5'd3,5'd0,6'h10),
          32'hFFFFFFFD, 32'd7, 32'hFFFFFFFF, 8'd10},                                   // R10 mult hi sign
        '{enc_r(5'd1,5'd2,5'd0,5'd0,6'h1A), enc_r(5'd0,5'd0,5'd3,5'd0,6'h12),
          32'hFFFFFFF9, 32'd2, 32'hFFFFFFFD, 8'd11},                                   // R11 div quotient
        '{enc_r(5'd1,5'd2,5'd0,5'd0,6'h1A), enc_r(5'd0,5'd0,5'd3,5'd0,6'h10),
          32'hFFFFFFF9, 32'd2, 32'hFFFFFFFF, 8'd11},                                   // R11 div remainder
        '{enc_r(5'd1,5'd2,5'd0,5'd0,6'h20), enc_r(5'd0,5'd0,5'd3,5'd0,6'h21),
          32'd5, 32'd6, 32'd0, 8'd12}                                                  // R12 r0 write dropped
    };

    // ---------- helpers ----------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; start = 1'b0; pre_iwe = 1'b0; pre_dwe = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic put_i(input int idx, input logic [31:0] w);
        @(negedge clk);
        pre_iwe = 1'b1; pre_iaddr = idx[IA_W-1:0]; pre_idata = w;
        @(negedge clk);
        pre_iwe = 1'b0;
    endtask

    task automatic put_d(input int idx, input logic [31:0] w);
        @(negedge clk);
        pre_dwe = 1'b1; pre_daddr = idx[DA_W-1:0]; pre_ddata = w;
        @(negedge clk);
        pre_dwe = 1'b0;
    endtask

    task automatic peek(input int idx, output logic [31:0] v);
        @(negedge clk);
        pre_daddr = idx[DA_W-1:0];
        #1 v = peek_ddata;
    endtask

    task automatic launch(input logic [31:0] addr);
        @(negedge clk);
        start_addr = addr; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // ---------- watchdog ----------
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    // ---------- main ----------
    initial begin
        logic [31:0] got;

        // R1: reset state
        repeat (2) @(negedge clk);
        chk("R1 pc after reset", pc_q, 32'h0);
        chk("R1 busy after reset", {31'd0, busy}, 32'h0);
        rst_n = 1'b1;

        // vector table
        for (int k = 0; k < NV; k++) begin
            do_reset();
            put_i(0, enc_i(6'h23, 5'd0, 5'd1, 16'd0));
            put_i(1, enc_i(6'h23, 5'd0, 5'd2, 16'd4));
            put_i(2, VECS[k].i1);
            put_i(3, VECS[k].i2);
            put_i(4, enc_i(6'h2B, 5'd0, 5'd3, 16'd8));
            put_i(5, enc_j(26'd5));
            put_d(0, VECS[k].a);
            put_d(1, VECS[k].b);
            put_d(2, 32'hA5A5A5A5);
            launch(32'h0);
            repeat (12) @(negedge clk);
            peek(2, got);
            chk($sformatf("R%0d vector %0d", VECS[k].req, k), got, VECS[k].exp);
        end

        // R2 / R3 / R13: start address masking, sequential PC, ignored start and preload
        do_reset();
        for (int i = 0; i < 32; i++) put_i(i, NOP);
        put_d(9, 32'h00001111);
        launch(32'h0000000E);
        chk("R2 start loads aligned pc", pc_q, 32'h0000000C);
        chk("R2 busy after start", {31'd0, busy}, 32'h1);
        @(negedge clk);
        chk("R3 pc advances by 4", pc_q, 32'h00000010);
        start_addr = 32'h0; start = 1'b1;
        pre_dwe = 1'b1; pre_daddr = 4'd9; pre_ddata = 32'h00002222;
        @(negedge clk);
        start = 1'b0; pre_dwe = 1'b0;
        chk("R2 start ignored while running", pc_q, 32'h00000014);
        peek(9, got);
        chk("R13 preload ignored while running", got, 32'h00001111);

        // R8 / R9: branches both ways, jump, backward self-loop
        do_reset();
        put_i(0,  enc_i(6'h08, 5'd0, 5'd1, 16'd3));
        put_i(1,  enc_i(6'h04, 5'd1, 5'd1, 16'd1));
        put_i(2,  enc_i(6'h08, 5'd0, 5'd1, 16'd99));
        put_i(3,  enc_i(6'h05, 5'd1, 5'd0, 16'd1));
        put_i(4,  enc_i(6'h08, 5'd0, 5'd1, 16'd77));
        put_i(5,  enc_i(6'h04, 5'd1, 5'd0, 16'd1));
        put_i(6,  enc_i(6'h08, 5'd1, 5'd1, 16'd1));
        put_i(7,  enc_j(26'd9));
        put_i(8,  enc_i(6'h08, 5'd0, 5'd1, 16'd55));
        put_i(9,  enc_i(6'h2B, 5'd0, 5'd1, 16'd12));
        put_i(10, enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF));
        put_d(3, 32'hA5A5A5A5);
        launch(32'h0);
        @(negedge clk);
        chk("R3 pc after addi", pc_q, 32'h00000004);
        @(negedge clk);
        chk("R8 beq taken target", pc_q, 32'h0000000C);
        @(negedge clk);
        chk("R8 bne taken target", pc_q, 32'h00000014);
        @(negedge clk);
        chk("R8 beq not taken falls through", pc_q, 32'h00000018);
        @(negedge clk);
        @(negedge clk);
        chk("R9 jump target", pc_q, 32'h00000024);
        repeat (6) @(negedge clk);
        chk("R8 backward branch self-loop", pc_q, 32'h00000028);
        peek(3, got);
        chk("R9 skipped paths not executed", got, 32'h00000004);

        // R11: divide by zero keeps HI/LO from the preceding mult
        do_reset();
        put_i(0, enc_i(6'h23, 5'd0, 5'd1, 16'd0));
        put_i(1, enc_i(6'h23, 5'd0, 5'd2, 16'd4));
        put_i(2, enc_r(5'd1, 5'd2, 5'd0, 5'd0, 6'h18));
        put_i(3, enc_r(5'd1, 5'd0, 5'd0, 5'd0, 6'h1A));
        put_i(4, enc_r(5'd0, 5'd0, 5'd3, 5'd0, 6'h12));
        put_i(5, enc_i(6'h2B, 5'd0, 5'd3, 16'd8));
        put_i(6, enc_r(5'd0, 5'd0, 5'd4, 5'd0, 6'h10));
        put_i(7, enc_i(6'h2B, 5'd0, 5'd4, 16'd12));
        put_i(8, enc_j(26'd8));
        put_d(0, 32'hFFFFFFFF);
        put_d(1, 32'd5);
        launch(32'h0);
        repeat (14) @(negedge clk);
        peek(2, got);
        chk("R11 LO kept on divide by zero", got, 32'hFFFFFFFB);
        peek(3, got);
        chk("R11 HI kept on divide by zero", got, 32'hFFFFFFFF);

        // R14: dot product of x = {3,-2,5,7,1} and y = {4,6,-1,2,9} -> 18
        do_reset();
        put_i(0,  enc_i(6'h08, 5'd0, 5'd1, 16'd0));
        put_i(1,  enc_i(6'h08, 5'd0, 5'd2, 16'd20));
        put_i(2,  enc_i(6'h08, 5'd0, 5'd3, 16'd0));
        put_i(3,  enc_i(6'h23, 5'd1, 5'd4, 16'd0));
        put_i(4,  enc_i(6'h23, 5'd1, 5'd5, 16'd20));
        put_i(5,  enc_r(5'd4, 5'd5, 5'd0, 5'd0, 6'h18));
        put_i(6,  enc_r(5'd0, 5'd0, 5'd6, 5'd0, 6'h12));
        put_i(7,  enc_r(5'd3, 5'd6, 5'd3, 5'd0, 6'h20));
        put_i(8,  enc_i(6'h08, 5'd1, 5'd1, 16'd4));
        put_i(9,  enc_i(6'h05, 5'd1, 5'd2, 16'hFFF9));
        put_i(10, enc_i(6'h2B, 5'd0, 5'd3, 16'd40));
        put_i(11, enc_j(26'd11));
        put_d(0, 32'd3);  put_d(1, 32'hFFFFFFFE); put_d(2, 32'd5);
        put_d(3, 32'd7);  put_d(4, 32'd1);
        put_d(5, 32'd4);  put_d(6, 32'd6); put_d(7, 32'hFFFFFFFF);
        put_d(8, 32'd2);  put_d(9, 32'd9);
        put_d(10, 32'hA5A5A5A5);
        launch(32'h0);
        repeat (60) @(negedge clk);
        peek(10, got);
        chk("R14 dot product Z", got, 32'd18);
        chk("R14 core parked on final jump", pc_q, 32'h0000002C);

        finish_up();
    end

endmodule